// File: doc/BRIEF.md
# Byte-Lane Read Word Assembler

This block builds a 32-bit read word from memory that can be either full width or halfword wide. The captured word is held in four 8-bit lanes. Each lane has its own enable and loads from its slice of the read data bus on the falling clock edge. A lane whose enable is low keeps what it already holds. A word can therefore be put together over more than one memory cycle without a full-width register load.

A small sequencer runs on the rising edge and drives the lane enables. In full-width mode a read is a single memory cycle with all four enables high. In halfword mode a read is two memory cycles:

- The first cycle enables the two low lanes while memory drives the low half of the bus.
- The second cycle enables the two high lanes while memory drives the upper half.

Each cycle waits for memory ready. A one-cycle done pulse reports that the word is complete.

Top module: `lane_read_capture`

## Requirements
- R1: While reset is asserted (`rst_n` low, asynchronous), the assembled word is zero, every lane enable is low, and `busy` and `done` are low.
- R2: On each falling clock edge, lane k (k = 0..3) loads `rd_data[8k+7:8k]` into `word_out[8k+7:8k]` when `lane_en[k]` is high. A lane with a low enable keeps its value.
- R3: Full-width mode (`half_mode` = 0): a request accepted in idle makes `lane_en` = 4'b1111 and `busy` high from the next cycle until ready is seen.
- R4: Halfword mode (`half_mode` = 1): the first memory cycle of an accepted request drives `lane_en` = 4'b0011.
- R5: In halfword mode, once ready is seen in the first cycle, the next cycle drives `lane_en` = 4'b1100.
- R6: While `mem_ready` is low during an access, the sequencer stays in its current memory cycle with unchanged lane enables.
- R7: In the cycle after ready is seen in the final memory cycle, `done` is high for exactly one cycle and `busy` is low. The word then holds all captured lanes: the full bus in full-width mode, or the upper half from the second cycle and the lower half from the first in halfword mode.
- R8: A request raised while `busy` is high is ignored. It changes neither the mode nor the sequence, and no further access follows `done` because of it.
- R9: In idle, all lane enables are low and the assembled word holds its value whatever appears on the data bus.
- R10: `half_mode` is sampled only in the cycle a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock: sequencer on the rising edge, lane capture on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_data | input | 32 | Read data bus from memory |
| half_mode | input | 1 | 1 = halfword-wide memory, 0 = full-width memory |
| req | input | 1 | Word read request, accepted only when idle |
| mem_ready | input | 1 | Memory cycle completes when high |
| lane_en | output | 4 | Per-lane capture enables |
| word_out | output | 32 | Assembled read word |
| done | output | 1 | One-cycle pulse when a word is complete |
| busy | output | 1 | High while a read is in progress |

## Verification
The assertions assume the following about the inputs:

- `rd_data` is settled before each falling edge.
- `mem_ready` and `req` change only after the rising edge, so the enables stay constant across each half cycle.

The bench changes every input one nanosecond after the rising edge and samples outputs at that same point. Data is therefore stable well before each falling-edge capture. The bench also puts deliberately unrelated bytes on the lanes that are not enabled. This makes a lane that wrongly loads show up in the assembled word.

// File: rtl/lane_read_capture.sv
module lane_read_capture #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES*LANE_W-1:0]   rd_data,
  input  logic                      half_mode,
  input  logic                      req,
  input  logic                      mem_ready,
  output logic [LANES-1:0]          lane_en,
  output logic [LANES*LANE_W-1:0]   word_out,
  output logic                      done,
  output logic                      busy
);
  localparam int HALF = LANES / 2;

  typedef enum logic [1:0] {S_IDLE, S_FULL, S_LO, S_HI} phase_t;
  phase_t phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= S_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (phase)
        S_IDLE: if (req) phase <= half_mode ? S_LO : S_FULL;
        S_FULL: if (mem_ready) begin phase <= S_IDLE; done <= 1'b1; end
        S_LO:   if (mem_ready) phase <= S_HI;
        S_HI:   if (mem_ready) begin phase <= S_IDLE; done <= 1'b1; end
        default: phase <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    lane_en = '0;
    case (phase)
      S_FULL: lane_en = '1;
      S_LO:   lane_en[HALF-1:0] = '1;
      S_HI:   lane_en[LANES-1:HALF] = '1;
      default: lane_en = '0;
    endcase
  end

  assign busy = (phase != S_IDLE);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)          word_out[k*LANE_W +: LANE_W] <= '0;
      else if (lane_en[k]) word_out[k*LANE_W +: LANE_W] <= rd_data[k*LANE_W +: LANE_W];
    end
  end
endmodule

module lane_read_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        mem_ready,
  input logic [3:0]  lane_en,
  input logic [31:0] word_out,
  input logic        done,
  input logic        busy
);
  // R9
  idle_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> lane_en == 4'b0000);
  // R9
  idle_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $stable(word_out));
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_ready |=> $stable(lane_en) && busy);
  // R5
  low_to_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_en == 4'b0011 && mem_ready |=> lane_en == 4'b1100);
  // R3
  full_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_en == 4'b1111 && mem_ready |=> done && !busy);
  // R4
  start_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> lane_en == 4'b1111 || lane_en == 4'b0011);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  busy_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(lane_en[3] && mem_ready) |=> busy && !done);
endmodule

bind lane_read_capture lane_read_capture_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .mem_ready(mem_ready),
  .lane_en(lane_en), .word_out(word_out), .done(done), .busy(busy)
);

// File: tb/lane_read_capture_tb.sv
`timescale 1ns/1ps
module lane_read_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] rd_data = '0;
  logic        half_mode = 1'b0;
  logic        req = 1'b0;
  logic        mem_ready = 1'b0;
  logic [3:0]  lane_en;
  logic [31:0] word_out;
  logic        done;
  logic        busy;

  int errors = 0;
  int checks = 0;
  logic [31:0] model = '0;

  always #2 clk = ~clk;

  lane_read_capture u_dut (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .half_mode(half_mode),
    .req(req), .mem_ready(mem_ready), .lane_en(lane_en), .word_out(word_out),
    .done(done), .busy(busy)
  );

  // {half, stall[1:0], first bus word, second bus word}
  localparam int NV = 6;
  localparam logic [66:0] VEC [NV] = '{
    {1'b0, 2'd0, 32'hDEADBEEF, 32'h0},
    {1'b1, 2'd0, 32'hAAAA1234, 32'h5678BBBB},
    {1'b1, 2'd2, 32'hFFFF0000, 32'h0000FFFF},
    {1'b0, 2'd3, 32'h01020304, 32'h0},
    {1'b1, 2'd1, 32'h9999C3C3, 32'hA5A51111},
    {1'b0, 2'd1, 32'h00000000, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic run_read(input logic hm, input int stall, input logic [31:0] d0,
                          input logic [31:0] d1, input logic poke_req);
    logic [3:0] first_en;
    first_en = hm ? 4'b0011 : 4'b1111;
    req = 1'b1; half_mode = hm; mem_ready = 1'b0;
    step();
    req = poke_req; half_mode = ~hm;
    rd_data = d0;
    for (int s = 0; s < stall; s++) begin
      chk(hm ? "R4 first-cycle enables" : "R3 full enables", {28'd0, lane_en}, {28'd0, first_en});
      chk("R6 busy during stall", {31'd0, busy}, 32'd1);
      step();
    end
    req = 1'b0;
    chk(hm ? "R4 first-cycle enables" : "R3 full enables", {28'd0, lane_en}, {28'd0, first_en});
    mem_ready = 1'b1;
    step();
    if (hm) begin
      model[15:0] = d0[15:0];
      chk("R5 second-cycle enables", {28'd0, lane_en}, 32'h0000000C);
      chk("R2 low lanes loaded, high kept", word_out, model);
      rd_data = d1;
      step();
      model[31:16] = d1[31:16];
    end else begin
      model = d0;
    end
    mem_ready = 1'b0;
    chk("R7 done pulse", {31'd0, done}, 32'd1);
    chk("R7 busy low at done", {31'd0, busy}, 32'd0);
    chk("R7 assembled word", word_out, model);
    step();
    chk("R7 done one cycle", {31'd0, done}, 32'd0);
    chk("R8 no extra access", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rd_data = 32'hCAFEF00D; req = 1'b1;
    repeat (3) step();
    chk("R1 reset word", word_out, 32'h0);
    chk("R1 reset enables", {28'd0, lane_en}, 32'h0);
    chk("R1 reset busy/done", {30'd0, busy, done}, 32'h0);
    req = 1'b0;
    rst_n = 1'b1;
    step();

    for (int i = 0; i < NV; i++) begin
      run_read(VEC[i][66], int'(VEC[i][65:64]), VEC[i][63:32], VEC[i][31:0], 1'b0);
    end

    // R8 and R10: request held high and mode flipped during a halfword access
    run_read(1'b1, 2, 32'h1111ABCD, 32'h7777EEEE, 1'b1);
    run_read(1'b0, 2, 32'h13579BDF, 32'h0, 1'b1);

    // R9: idle bus activity leaves the word alone
    for (int j = 0; j < 4; j++) begin
      rd_data = 32'h0F0F0F0F ^ (32'h11111111 * j);
      mem_ready = j[0];
      step();
      chk("R9 idle enables low", {28'd0, lane_en}, 32'h0);
      chk("R9 idle word held", word_out, model);
    end
    mem_ready = 1'b0;

    // R1: reset in the middle of an access
    req = 1'b1; half_mode = 1'b1;
    step();
    req = 1'b0; rd_data = 32'h87654321;
    step();
    rst_n = 1'b0;
    #1;
    chk("R1 mid-access reset word", word_out, 32'h0);
    chk("R1 mid-access reset busy", {31'd0, busy}, 32'd0);
    chk("R1 mid-access reset enables", {28'd0, lane_en}, 32'h0);
    step();
    rst_n = 1'b1;
    model = '0;
    step();
    run_read(1'b1, 0, 32'h0000BEEF, 32'hFACE0000, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule